// File: doc/BRIEF.md
# Pin Event Time-Stamp Queue

This block watches up to four digital input pins and records when they change, measured against a free-running timer that comes in as an input bus. Each pin has an enable and a two-bit trigger mode that together decide which transitions count as events. All events seen at one clock edge become a single record. The record holds the timer value at that edge and a mask of the pins that fired. Records go into a short first-in first-out queue. The oldest record then moves into a holding register, where software reads it.

Software reads the holding register in two steps. A status read comes first. A time read follows, and it releases the register so the next queued record can move in. Two interrupt pulses help software keep up. One fires when the holding register goes from empty to loaded. The other fires when the queue behind the holding register reaches a fill threshold. If the queue is full, new events are lost and a sticky overflow flag is set.

Top module: `pin_event_logger`

## Requirements
- R1: While reset is asserted, and until the first event after it, the outputs are in a known state. `hold_valid`, `status_out`, `time_out`, `ovf_flag`, `irq_data` and `irq_thresh` are all zero.
- R2: Pin i uses mode field `pin_mode[2i+1:2i]`. Value 01 captures a rising level change, 10 a falling one and 11 either. A change is judged against the pin's level at the previous clock edge.
- R3: Mode 00 captures only every eighth rising edge of the pin. The count restarts from zero whenever the pin is disabled or set to another mode.
- R4: When `pin_en[i]` is 0, no transition on pin i is ever captured.
- R5: All events at one clock edge make one record. In `status_out`, bit i is set exactly when pin i fired. `time_out` is the `timer_val` sampled at that edge.
- R6: An event captured at edge E, while the queue and the holding register are both empty, is in the holding register after edge E+1. `irq_data` is high for exactly that one cycle, and it pulses on every transition of the holding register from empty to loaded.
- R7: A `rd_time` pulse releases the holding register only if `rd_status` has been pulsed since the register was loaded. Any other `rd_time` is ignored and leaves `status_out` and `time_out` unchanged.
- R8: Records leave the queue in the order they were captured. The queue holds 7 records in addition to the holding register.
- R9: `irq_thresh` pulses for one cycle when the queue, not counting the holding register, fills to 4 records.
- R10: An event that arrives while the queue is full, with no record leaving in the same cycle, is dropped and sets `ovf_flag`. A `rd_status` pulse clears `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | 16 | Free-running time base |
| pins_in | input | 4 | Monitored pins, synchronous to clk |
| pin_en | input | 4 | Per-pin capture enable |
| pin_mode | input | 8 | Two-bit trigger mode per pin |
| rd_status | input | 1 | Status read strobe |
| rd_time | input | 1 | Time read strobe, advances the queue |
| status_out | output | 4 | Mask of the pins that fired for the held record |
| time_out | output | 16 | Time stamp of the held record |
| hold_valid | output | 1 | Holding register is loaded |
| ovf_flag | output | 1 | Sticky record-dropped flag |
| irq_data | output | 1 | Pulse: holding register became loaded |
| irq_thresh | output | 1 | Pulse: queue reached the threshold |

## Verification
A corrupted queue pointer or count shows up within a few reads. Records come back out of order, with wrong time stamps, or one too many or too few. The threshold pulse then lands on the wrong event, or the overflow flag rises one event early or late. A bad divide-by-eight counter moves the single capture to a rising edge other than the eighth. A broken read-order latch either advances on a lone time read or never advances, and the very next sample of `time_out` shows it.

// File: rtl/pel_pkg.sv
`timescale 1ns/1ps
package pel_pkg;
  typedef enum logic [1:0] {
    TRIG_DIV8 = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_BOTH = 2'b11
  } trig_mode_e;
endpackage

// File: rtl/pel_pin_trig.sv
`timescale 1ns/1ps
module pel_pin_trig #(
  parameter int DIV_N = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pin_now,
  input  logic                   en,
  input  pel_pkg::trig_mode_e    mode,
  output logic                   fire
);
  localparam int CNTW = (DIV_N > 1) ? $clog2(DIV_N) : 1;

  logic            pin_q;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            rise, fall;

  assign rise = pin_now & ~pin_q;
  assign fall = ~pin_now & pin_q;

  always_comb begin
    cnt_d = '0;
    fire  = 1'b0;
    if (en) begin
      unique case (mode)
        pel_pkg::TRIG_DIV8: begin
          cnt_d = cnt_q;
          if (rise) begin
            if (cnt_q == CNTW'(DIV_N - 1)) begin
              fire  = 1'b1;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        pel_pkg::TRIG_RISE: fire = rise;
        pel_pkg::TRIG_FALL: fire = fall;
        pel_pkg::TRIG_BOTH: fire = rise | fall;
        default:            fire = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      pin_q <= pin_now;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pel_fifo.sv
`timescale 1ns/1ps
module pel_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = push ? bump(wr_q) : wr_q;
    rd_d  = pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/pin_event_logger.sv
`timescale 1ns/1ps
module pin_event_logger #(
  parameter int NUM_PINS   = 4,
  parameter int TIME_W     = 16,
  parameter int FIFO_DEPTH = 7,
  parameter int THRESH     = 4,
  parameter int DIV_N      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TIME_W-1:0]     timer_val,
  input  logic [NUM_PINS-1:0]   pins_in,
  input  logic [NUM_PINS-1:0]   pin_en,
  input  logic [2*NUM_PINS-1:0] pin_mode,
  input  logic                  rd_status,
  input  logic                  rd_time,
  output logic [NUM_PINS-1:0]   status_out,
  output logic [TIME_W-1:0]     time_out,
  output logic                  hold_valid,
  output logic                  ovf_flag,
  output logic                  irq_data,
  output logic                  irq_thresh
);
  localparam int EW = NUM_PINS + TIME_W;
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // per-pin trigger logic
  logic [NUM_PINS-1:0] fire;
  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    pel_pin_trig #(.DIV_N(DIV_N)) u_trig (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .pin_now (pins_in[gi]),
      .en      (pin_en[gi]),
      .mode    (pel_pkg::trig_mode_e'(pin_mode[2*gi +: 2])),
      .fire    (fire[gi])
    );
  end

  // queue
  logic          push, pop, take, drop, any_fire;
  logic [EW-1:0] fifo_head;
  logic [CW-1:0] fifo_cnt, cnt_nxt;
  logic          fifo_full, fifo_empty;

  pel_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (push),
    .push_data ({fire, timer_val}),
    .pop       (pop),
    .head      (fifo_head),
    .count     (fifo_cnt),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  // holding register and flags
  logic                hold_v_q, hold_v_d;
  logic [NUM_PINS-1:0] hold_st_q, hold_st_d;
  logic [TIME_W-1:0]   hold_t_q, hold_t_d;
  logic                armed_q, armed_d;
  logic                ovf_q, ovf_d;
  logic                irqd_q, irqd_d;
  logic                irqt_q, irqt_d;

  always_comb begin
    any_fire = |fire;
    take     = rd_time & armed_q & hold_v_q;
    pop      = ~fifo_empty & (~hold_v_q | take);
    push     = any_fire & (~fifo_full | pop);
    drop     = any_fire & fifo_full & ~pop;
    cnt_nxt  = fifo_cnt + CW'(push) - CW'(pop);

    hold_v_d  = hold_v_q;
    hold_st_d = hold_st_q;
    hold_t_d  = hold_t_q;
    if (pop) begin
      hold_v_d  = 1'b1;
      hold_st_d = fifo_head[EW-1:TIME_W];
      hold_t_d  = fifo_head[TIME_W-1:0];
    end else if (take) begin
      hold_v_d  = 1'b0;
    end

    armed_d = armed_q;
    if (pop || take)                armed_d = 1'b0;
    else if (rd_status && hold_v_q) armed_d = 1'b1;

    ovf_d = ovf_q;
    if (drop)           ovf_d = 1'b1;
    else if (rd_status) ovf_d = 1'b0;

    irqd_d = pop & ~hold_v_q;
    irqt_d = (cnt_nxt >= CW'(THRESH)) && (fifo_cnt < CW'(THRESH));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hold_v_q  <= 1'b0;
      hold_st_q <= '0;
      hold_t_q  <= '0;
      armed_q   <= 1'b0;
      ovf_q     <= 1'b0;
      irqd_q    <= 1'b0;
      irqt_q    <= 1'b0;
    end else begin
      hold_v_q  <= hold_v_d;
      hold_st_q <= hold_st_d;
      hold_t_q  <= hold_t_d;
      armed_q   <= armed_d;
      ovf_q     <= ovf_d;
      irqd_q    <= irqd_d;
      irqt_q    <= irqt_d;
    end
  end

  assign status_out = hold_v_q ? hold_st_q : '0;
  assign time_out   = hold_v_q ? hold_t_q  : '0;
  assign hold_valid = hold_v_q;
  assign ovf_flag   = ovf_q;
  assign irq_data   = irqd_q;
  assign irq_thresh = irqt_q;
endmodule

// File: rtl/pel_checker.sv
`timescale 1ns/1ps
module pel_checker #(
  parameter int NUM_PINS   = 4,
  parameter int TIME_W     = 16,
  parameter int FIFO_DEPTH = 7,
  parameter int THRESH     = 4
) (
  input logic                               clk,
  input logic                               rst_sync_n,
  input logic                               rd_time,
  input logic [NUM_PINS-1:0]                status_out,
  input logic [TIME_W-1:0]                  time_out,
  input logic                               hold_valid,
  input logic                               ovf_flag,
  input logic                               irq_data,
  input logic                               irq_thresh,
  input logic [$clog2(FIFO_DEPTH+1)-1:0]    fifo_cnt
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold_valid && !rd_time |=> hold_valid && $stable(time_out) && $stable(status_out)); // R7

  AST_DATA_IRQ_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_data |-> hold_valid && !$past(hold_valid)); // R6

  AST_THRESH_LEVEL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_thresh |-> fifo_cnt == CW'(THRESH)); // R9

  AST_OVF_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ovf_flag) |-> $past(fifo_cnt) == CW'(FIFO_DEPTH)); // R10

  AST_RECORD_HAS_PIN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold_valid |-> status_out != '0); // R5
endmodule

bind pin_event_logger pel_checker #(
  .NUM_PINS(NUM_PINS), .TIME_W(TIME_W), .FIFO_DEPTH(FIFO_DEPTH), .THRESH(THRESH)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .rd_time    (rd_time),
  .status_out (status_out),
  .time_out   (time_out),
  .hold_valid (hold_valid),
  .ovf_flag   (ovf_flag),
  .irq_data   (irq_data),
  .irq_thresh (irq_thresh),
  .fifo_cnt   (fifo_cnt)
);

// File: tb/pin_event_logger_tb.sv
`timescale 1ns/1ps
module pin_event_logger_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] tmr = '0;
  logic [3:0]  pins_in, pin_en;
  logic [7:0]  pin_mode;
  logic        rd_status, rd_time;
  logic [3:0]  status_out;
  logic [15:0] time_out;
  logic        hold_valid, ovf_flag, irq_data, irq_thresh;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;
  always @(posedge clk) tmr <= tmr + 16'd1;

  pin_event_logger u_dut (
    .clk(clk), .rst_n(rst_n), .timer_val(tmr), .pins_in(pins_in),
    .pin_en(pin_en), .pin_mode(pin_mode), .rd_status(rd_status),
    .rd_time(rd_time), .status_out(status_out), .time_out(time_out),
    .hold_valid(hold_valid), .ovf_flag(ovf_flag), .irq_data(irq_data),
    .irq_thresh(irq_thresh)
  );

  // {mode[7:0], en[3:0], pins[3:0], expected mask[3:0]}
  localparam logic [19:0] VEC [10] = '{
    {8'h55, 4'hF, 4'b0001, 4'b0001},
    {8'h55, 4'hF, 4'b0011, 4'b0010},
    {8'h55, 4'hF, 4'b0000, 4'b0000},
    {8'hAA, 4'hF, 4'b0011, 4'b0000},
    {8'hAA, 4'hF, 4'b0000, 4'b0011},
    {8'hFF, 4'hF, 4'b1111, 4'b1111},
    {8'hFF, 4'h5, 4'b0000, 4'b0101},
    {8'hFF, 4'h0, 4'b1111, 4'b0000},
    {8'h79, 4'hF, 4'b0000, 4'b0110},
    {8'h79, 4'hF, 4'b1111, 4'b1101}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_read();
    @(negedge clk); rd_status = 1'b1;
    @(negedge clk); rd_status = 1'b0; rd_time = 1'b1;
    @(negedge clk); rd_time = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 12 && hold_valid; i++) do_read();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] t;
    logic [15:0] ts [10];
    rst_n = 1'b0; pins_in = '0; pin_en = '0; pin_mode = 8'h55;
    rd_status = 1'b0; rd_time = 1'b0;
    repeat (3) @(negedge clk);
    chk(hold_valid == 0 && status_out == 0 && time_out == 0, "R1 outputs in reset",
        {hold_valid, status_out, time_out}, 0);
    chk(ovf_flag == 0 && irq_data == 0 && irq_thresh == 0, "R1 flags in reset",
        {ovf_flag, irq_data, irq_thresh}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(hold_valid == 0, "R1 idle after reset", hold_valid, 0);

    // table walk: R2 R4 R5 R6
    foreach (VEC[v]) begin
      @(negedge clk);
      pin_mode = VEC[v][19:12]; pin_en = VEC[v][11:8]; pins_in = VEC[v][7:4];
      t = tmr;
      @(negedge clk); @(negedge clk);
      if (VEC[v][3:0] != 0) begin
        chk(hold_valid == 1, "R6 record loaded", hold_valid, 1);
        chk(irq_data == 1, "R6 data irq pulse", irq_data, 1);
        chk(status_out == VEC[v][3:0], "R2/R5 pin mask", status_out, VEC[v][3:0]);
        chk(time_out == t, "R5 time stamp", time_out, t);
        do_read();
        chk(hold_valid == 0, "R7 release after ordered read", hold_valid, 0);
      end else begin
        chk(hold_valid == 0, "R2/R4 no capture", hold_valid, 0);
      end
    end

    // R7: lone time read is ignored
    @(negedge clk); pin_mode = 8'hFF; pin_en = 4'h1; pins_in = 4'b1110; ts[0] = tmr;
    @(negedge clk); pins_in = 4'b1111; ts[1] = tmr;
    @(negedge clk); @(negedge clk);
    chk(time_out == ts[0], "R8 first record", time_out, ts[0]);
    rd_time = 1'b1;
    @(negedge clk); rd_time = 1'b0;
    @(negedge clk);
    chk(hold_valid == 1 && time_out == ts[0], "R7 lone time read ignored", time_out, ts[0]);
    do_read();
    chk(hold_valid == 1 && time_out == ts[1], "R8 second record", time_out, ts[1]);
    drain();
    chk(hold_valid == 0, "R8 drained", hold_valid, 0);

    // R3: every eighth rising edge
    @(negedge clk); pin_en = 4'h0; pins_in = 4'b0000;
    @(negedge clk); pin_mode = 8'h00; pin_en = 4'h1;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (k == 14) chk(hold_valid == 0, "R3 nothing before eighth rise", hold_valid, 0);
      t = tmr;
      pins_in[0] = ~pins_in[0];
    end
    @(negedge clk); @(negedge clk);
    chk(hold_valid == 1 && status_out == 4'b0001, "R3 eighth rise captured", status_out, 1);
    chk(time_out == t, "R3 time of eighth rise", time_out, t);
    drain();

    // R9 R10: threshold and overflow
    @(negedge clk); pin_en = 4'h0; pins_in = 4'b0000;
    @(negedge clk); pin_mode = 8'hFF; pin_en = 4'h1;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      chk(irq_thresh == (k == 6), "R9 threshold pulse timing", irq_thresh, (k == 6));
      if (k == 9) chk(ovf_flag == 0, "R10 no overflow at full", ovf_flag, 0);
      ts[k] = tmr;
      pins_in[0] = ~pins_in[0];
    end
    @(negedge clk);
    chk(ovf_flag == 1, "R10 overflow on drop", ovf_flag, 1);
    for (int k = 1; k <= 8; k++) begin
      chk(hold_valid == 1 && time_out == ts[k], "R8 order after overflow", time_out, ts[k]);
      do_read();
      if (k == 1) chk(ovf_flag == 0, "R10 cleared by status read", ovf_flag, 0);
    end
    chk(hold_valid == 0, "R10 dropped event absent", hold_valid, 0);

    // R1: reset during activity
    @(negedge clk); pins_in[0] = ~pins_in[0];
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(hold_valid == 0 && status_out == 0 && time_out == 0, "R1 reset clears record",
        {hold_valid, status_out}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule